// File: doc/BRIEF.md
# Look-ahead first-order IIR low-pass filter

This block smooths a stream of signed fixed-point samples with the one-pole recursion y[n+1] = a·y[n] + b·x[n]. The recursion is unrolled by one step into y[n+2] = a²·y[n] + a·b·x[n] + b·x[n+1]. The loop therefore holds two registers. The multiply happens in one clock period and the rounding add in the next, which removes the single-cycle multiply-add that limits the clock rate of the plain form. The two input-dependent terms a·b·x[n] + b·x[n+1] form a short feed-forward FIR section. That section is pipelined to a depth set by a parameter, and the depth does not change the transfer function.

The coefficients a and b arrive on input ports and are captured by a load strobe. The squared and cross coefficients a² and a·b are formed once, when the load happens, and are kept at full width. The load also clears the filter state. Samples enter with a valid strobe. The whole datapath advances only on accepted samples, so idle cycles leave the result unchanged. When samples arrive back to back, the block produces one filtered value per clock. The fixed latency, counted in accepted samples, equals the feed-forward depth `FF_STAGES`.

Top module: `iir_la_top`

## Requirements
- R1: Number formats and output value. Samples are DATA_W-bit signed integers. `coef_a` and `coef_b` are COEF_W-bit signed values with COEF_FRAC fractional bits (default Q1.17). Each output equals sat(floor((a²·y[j-1] + a·b·x[j-1] + b·x[j]·2^COEF_FRAC + 2^(2·COEF_FRAC-1)) / 2^(2·COEF_FRAC))). In this formula a and b are the raw integers, x[-1] = y[-1] = y[0] = 0, the values y fed back are the rounded and saturated outputs, and every product is kept at full width.
- R2: When |a| ≤ 0.5 and no output saturates, each output differs by at most one LSB from the unrounded direct-form recursion y[n+1] = a·y[n] + b·x[n].
- R3: `out_valid` is high for one cycle after each accepted sample (`in_valid` high, `coef_load` low), but only once at least FF_STAGES samples have been accepted before it since the last clear. With s counting the accepted samples from zero, sample s yields `out_data` = y[s-FF_STAGES+1]. Before that point `out_data` stays 0.
- R4: A cycle with `in_valid` low changes no state. In the next cycle `out_valid` is low and `out_data` holds its value, whatever is on `in_data`. The output sequence is the same with or without idle gaps.
- R5: `coef_load` high captures `coef_a` and `coef_b` and clears all filter state. The sample presented in that cycle is ignored. In the next cycle `out_valid` is low and `out_data` is 0, and the following samples are filtered with the new coefficients.
- R6: Outputs clamp to the DATA_W-bit signed range (-32768 and 32767 by default), and the clamped value is the one fed back.
- R7: A synchronous reset clears all delay registers and sets the coefficients to zero. After reset `out_valid` is 0 and `out_data` is 0, and later samples produce 0.
- R8: With `in_valid` held high after the fill, `out_valid` is high in every cycle, one output per clock.
- R9: The coefficient a = -1.0 (the most negative code) is handled exactly, so a² = +1.0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| coef_load | input | 1 | Capture coefficients and clear the filter state |
| coef_a | input | COEF_W | Feedback coefficient a, signed fixed point |
| coef_b | input | COEF_W | Input gain b, signed fixed point |
| in_valid | input | 1 | Sample strobe |
| in_data | input | DATA_W | Input sample, signed |
| out_valid | output | 1 | Output strobe |
| out_data | output | DATA_W | Filtered sample, signed, saturated |

## Verification
The bound checker checks the handshake timing on every cycle. A load always empties the output. An idle cycle leaves `out_valid` low and `out_data` frozen. `out_valid` never rises before FF_STAGES samples have filled the feed-forward pipe, and once that pipe is full every accepted sample produces an output in the next cycle. Only the bench's scenarios can show the arithmetic. These are bit-exact agreement with the unrolled recursion under random data and random gaps, the one-LSB bound against the direct form, clamping at both rails, and the exact oscillation when a = -1.0.

// File: rtl/iir_la_pkg.sv
package iir_la_pkg;
   // Default configuration shared by the filter and its checker.
   localparam int DEF_DATA_W    = 16;
   localparam int DEF_COEF_W    = 18;
   localparam int DEF_COEF_FRAC = 17;
   localparam int DEF_FF_STAGES = 2;

   // Latency in accepted samples from one input to its output.
   function automatic int sample_latency(input int ff_stages);
      return ff_stages;
   endfunction
endpackage

// File: rtl/iir_la_coef.sv
// Captures b and forms a*a and a*b at full width on a load strobe.
module iir_la_coef #(
   parameter int COEF_W = 18,
   parameter int SQ_W   = 36
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     load,
   input  logic signed [COEF_W-1:0] a,
   input  logic signed [COEF_W-1:0] b,
   output logic signed [SQ_W-1:0]   a_sq,
   output logic signed [SQ_W-1:0]   a_b,
   output logic signed [COEF_W-1:0] b_hold
);
   logic signed [SQ_W-1:0]   a_sq_q;
   logic signed [SQ_W-1:0]   a_b_q;
   logic signed [COEF_W-1:0] b_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         a_sq_q <= '0;
         a_b_q  <= '0;
         b_q    <= '0;
      end else if (load) begin
         a_sq_q <= SQ_W'(a) * SQ_W'(a);
         a_b_q  <= SQ_W'(a) * SQ_W'(b);
         b_q    <= b;
      end
   end

   assign a_sq   = a_sq_q;
   assign a_b    = a_b_q;
   assign b_hold = b_q;
endmodule

// File: rtl/iir_la_fir.sv
// Feed-forward section: f = a*b*x[k-1] + b*x[k], aligned to 2*COEF_FRAC fraction bits.
module iir_la_fir #(
   parameter int DATA_W    = 16,
   parameter int COEF_W    = 18,
   parameter int COEF_FRAC = 17,
   parameter int SQ_W      = 36,
   parameter int ACC_W     = 54,
   parameter int STAGES    = 2
) (
   input  logic                     clk,
   input  logic                     clr,
   input  logic                     en,
   input  logic signed [DATA_W-1:0] x,
   input  logic signed [SQ_W-1:0]   a_b,
   input  logic signed [COEF_W-1:0] b,
   output logic signed [ACC_W-1:0]  f
);
   localparam int PAB_W = SQ_W + DATA_W;
   localparam int PB_W  = COEF_W + DATA_W;

   logic signed [DATA_W-1:0] x_prev_q;
   logic signed [PAB_W-1:0]  p_ab;
   logic signed [PB_W-1:0]   p_b;

   assign p_ab = PAB_W'(a_b) * PAB_W'(x_prev_q);
   assign p_b  = PB_W'(b) * PB_W'(x);

   always_ff @(posedge clk) begin
      if (clr)     x_prev_q <= '0;
      else if (en) x_prev_q <= x;
   end

   generate
      if (STAGES == 1) begin : g_fused
         logic signed [ACC_W-1:0] sum_q;
         always_ff @(posedge clk) begin
            if (clr)     sum_q <= '0;
            else if (en) sum_q <= ACC_W'(p_ab) + (ACC_W'(p_b) <<< COEF_FRAC);
         end
         assign f = sum_q;
      end else begin : g_split
         logic signed [PAB_W-1:0] p_ab_q;
         logic signed [PB_W-1:0]  p_b_q;
         logic signed [ACC_W-1:0] pipe_q [STAGES-1];
         always_ff @(posedge clk) begin
            if (clr) begin
               p_ab_q <= '0;
               p_b_q  <= '0;
               for (int i = 0; i < STAGES-1; i++) pipe_q[i] <= '0;
            end else if (en) begin
               p_ab_q    <= p_ab;
               p_b_q     <= p_b;
               pipe_q[0] <= ACC_W'(p_ab_q) + (ACC_W'(p_b_q) <<< COEF_FRAC);
               for (int i = 1; i < STAGES-1; i++) pipe_q[i] <= pipe_q[i-1];
            end
         end
         assign f = pipe_q[STAGES-2];
      end
   endgenerate
endmodule

// File: rtl/iir_la_loop.sv
// Two-register feedback loop: multiply in one period, round-and-add in the next.
module iir_la_loop #(
   parameter int DATA_W  = 16,
   parameter int SQ_W    = 36,
   parameter int SQ_FRAC = 34,
   parameter int ACC_W   = 54
) (
   input  logic                     clk,
   input  logic                     clr,
   input  logic                     en,
   input  logic signed [SQ_W-1:0]   a_sq,
   input  logic signed [ACC_W-1:0]  f,
   output logic signed [DATA_W-1:0] y
);
   localparam int M_W = SQ_W + DATA_W;
   localparam logic signed [ACC_W-1:0] HALF  = ACC_W'(1) <<< (SQ_FRAC-1);
   localparam logic signed [ACC_W-1:0] Y_MAX = {{(ACC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
   localparam logic signed [ACC_W-1:0] Y_MIN = {{(ACC_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

   logic signed [M_W-1:0]    m_q;
   logic signed [DATA_W-1:0] y_q;
   logic signed [ACC_W-1:0]  sum;
   logic signed [ACC_W-1:0]  rnd;
   logic signed [DATA_W-1:0] y_next;

   always_comb begin
      sum = ACC_W'(m_q) + f;
      rnd = (sum + HALF) >>> SQ_FRAC;
      if (rnd > Y_MAX)      y_next = Y_MAX[DATA_W-1:0];
      else if (rnd < Y_MIN) y_next = Y_MIN[DATA_W-1:0];
      else                  y_next = rnd[DATA_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (clr) begin
         m_q <= '0;
         y_q <= '0;
      end else if (en) begin
         m_q <= M_W'(a_sq) * M_W'(y_q);
         y_q <= y_next;
      end
   end

   assign y = y_q;
endmodule

// File: rtl/iir_la_top.sv
module iir_la_top
   import iir_la_pkg::*;
#(
   parameter int DATA_W    = DEF_DATA_W,
   parameter int COEF_W    = DEF_COEF_W,
   parameter int COEF_FRAC = DEF_COEF_FRAC,
   parameter int FF_STAGES = DEF_FF_STAGES
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     coef_load,
   input  logic signed [COEF_W-1:0] coef_a,
   input  logic signed [COEF_W-1:0] coef_b,
   input  logic                     in_valid,
   input  logic signed [DATA_W-1:0] in_data,
   output logic                     out_valid,
   output logic signed [DATA_W-1:0] out_data
);
   localparam int SQ_W    = 2 * COEF_W;
   localparam int SQ_FRAC = 2 * COEF_FRAC;
   localparam int ACC_W   = SQ_W + DATA_W + 2;
   localparam int LATENCY = sample_latency(FF_STAGES);
   localparam int CNT_W   = $clog2(LATENCY + 1);

   if (FF_STAGES < 1) begin : g_bad_stages
      $error("FF_STAGES must be at least 1");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("DATA_W must be at least 2");
   end
   if (COEF_FRAC < 1 || COEF_FRAC >= COEF_W) begin : g_bad_frac
      $error("COEF_FRAC must lie in 1..COEF_W-1");
   end

   logic                     clr;
   logic                     step;
   logic signed [SQ_W-1:0]   a_sq;
   logic signed [SQ_W-1:0]   a_b;
   logic signed [COEF_W-1:0] b_hold;
   logic signed [ACC_W-1:0]  ff_sum;
   logic [CNT_W-1:0]         fill_q;
   logic                     ov_q;

   assign clr  = rst | coef_load;
   assign step = in_valid & ~coef_load;

   iir_la_coef #(.COEF_W(COEF_W), .SQ_W(SQ_W)) coef_i (
      .clk(clk), .rst(rst), .load(coef_load), .a(coef_a), .b(coef_b),
      .a_sq(a_sq), .a_b(a_b), .b_hold(b_hold)
   );

   iir_la_fir #(
      .DATA_W(DATA_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC),
      .SQ_W(SQ_W), .ACC_W(ACC_W), .STAGES(FF_STAGES)
   ) fir_i (
      .clk(clk), .clr(clr), .en(step), .x(in_data),
      .a_b(a_b), .b(b_hold), .f(ff_sum)
   );

   iir_la_loop #(
      .DATA_W(DATA_W), .SQ_W(SQ_W), .SQ_FRAC(SQ_FRAC), .ACC_W(ACC_W)
   ) loop_i (
      .clk(clk), .clr(clr), .en(step), .a_sq(a_sq), .f(ff_sum), .y(out_data)
   );

   always_ff @(posedge clk) begin
      if (clr) begin
         fill_q <= '0;
         ov_q   <= 1'b0;
      end else begin
         ov_q <= step && (fill_q == CNT_W'(LATENCY));
         if (step && fill_q != CNT_W'(LATENCY)) fill_q <= fill_q + CNT_W'(1);
      end
   end

   assign out_valid = ov_q;
endmodule

// File: rtl/iir_la_chk.sv
module iir_la_chk #(
   parameter int DATA_W    = 16,
   parameter int FF_STAGES = 2
) (
   input logic              clk,
   input logic              rst,
   input logic              coef_load,
   input logic              in_valid,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_data
);
   localparam int CW = $clog2(FF_STAGES + 2);

   logic [CW-1:0] seen_q;

   always_ff @(posedge clk) begin
      if (rst || coef_load) seen_q <= '0;
      else if (in_valid && seen_q != CW'(FF_STAGES + 1)) seen_q <= seen_q + CW'(1);
   end

   p_load_clears_r5: assert property (@(posedge clk) disable iff (rst)
      coef_load |=> (!out_valid && out_data == '0));

   p_idle_freeze_r4: assert property (@(posedge clk) disable iff (rst)
      (!in_valid && !coef_load) |=> (!out_valid && $stable(out_data)));

   p_fill_gate_r3: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (seen_q > CW'(FF_STAGES)));

   p_steady_flow_r8: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !coef_load && seen_q >= CW'(FF_STAGES)) |=> out_valid);
endmodule

bind iir_la_top iir_la_chk #(.DATA_W(DATA_W), .FF_STAGES(FF_STAGES)) chk_i (
   .clk(clk), .rst(rst), .coef_load(coef_load), .in_valid(in_valid),
   .out_valid(out_valid), .out_data(out_data)
);

// File: tb/iir_la_top_tb_top.sv
`timescale 1ns/1ps
module iir_la_top_tb_top;
   localparam int D    = 2;
   localparam int MAXN = 256;

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic               coef_load = 1'b0;
   logic signed [17:0] coef_a = '0;
   logic signed [17:0] coef_b = '0;
   logic               in_valid = 1'b0;
   logic signed [15:0] in_data = '0;
   logic               out_valid;
   logic signed [15:0] out_data;

   int     checks = 0;
   int     errors = 0;
   bit     done = 1'b0;
   int     xs [0:MAXN-1];
   longint ym [0:MAXN];
   real    yd [0:MAXN];

   always #2 clk = ~clk;

   iir_la_top #(.DATA_W(16), .COEF_W(18), .COEF_FRAC(17), .FF_STAGES(D)) dut_i (
      .clk(clk), .rst(rst), .coef_load(coef_load), .coef_a(coef_a), .coef_b(coef_b),
      .in_valid(in_valid), .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic longint rnd_sat(input longint v);
      longint r;
      r = (v + (longint'(1) <<< 33)) >>> 34;
      if (r > 32767)  r = 32767;
      if (r < -32768) r = -32768;
      return r;
   endfunction

   // Expected outputs from the unrolled recursion (R1) and the exact direct form (R2).
   task automatic build_model(input longint a, input longint b, input int n);
      longint a2, ab, yprev, ycur, xprev, ynext;
      a2 = a * a; ab = a * b; yprev = 0; ycur = 0; xprev = 0;
      ym[0] = 0; yd[0] = 0.0;
      for (int j = 0; j < n; j++) begin
         ynext = rnd_sat(a2 * yprev + ab * xprev + (b * longint'(xs[j]) <<< 17));
         ym[j+1] = ynext;
         yprev = ycur; ycur = ynext; xprev = longint'(xs[j]);
         yd[j+1] = (real'(a) / 131072.0) * yd[j] + (real'(b) / 131072.0) * real'(xs[j]);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; in_valid = 1'b0; coef_load = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      check(out_valid == 1'b0, "R7", "out_valid after reset", longint'(out_valid), 0);
      check(out_data == 16'sd0, "R7", "out_data after reset", longint'(out_data), 0);
   endtask

   task automatic load_coefs(input longint a, input longint b);
      coef_load = 1'b1; coef_a = 18'(a); coef_b = 18'(b);
      in_valid = 1'b1; in_data = 16'sd12345;   // must be ignored
      @(posedge clk); @(negedge clk);
      coef_load = 1'b0; in_valid = 1'b0;
      check(out_valid == 1'b0, "R5", "out_valid after load", longint'(out_valid), 0);
      check(out_data == 16'sd0, "R5", "out_data after load", longint'(out_data), 0);
   endtask

   // Drives xs[0..n-1] with idle gaps and compares each cycle; starts on a cleared filter.
   task automatic run_stream(input int n, input int idle_pct, input bit cmp_direct);
      int k;
      bit go;
      longint last, exp;
      real diff;
      k = 0;
      last = longint'(out_data);
      while (k < n) begin
         go = (int'($urandom_range(99)) >= idle_pct);
         in_valid = go;
         in_data  = go ? 16'(xs[k]) : 16'sh7abc;
         @(posedge clk); @(negedge clk);
         if (go) begin
            if (k >= D) begin
               exp = ym[k-D+1];
               check(out_valid == 1'b1, (idle_pct == 0) ? "R8" : "R3", "out_valid after fill",
                     longint'(out_valid), 1);
               check(longint'(out_data) == exp, "R1", "filtered value", longint'(out_data), exp);
               if (cmp_direct) begin
                  diff = real'(out_data) - yd[k-D+1];
                  if (diff < 0.0) diff = -diff;
                  check(diff <= 1.0, "R2", "distance to direct form",
                        longint'(out_data), longint'($rtoi(yd[k-D+1])));
               end
            end else begin
               check(out_valid == 1'b0, "R3", "out_valid during fill", longint'(out_valid), 0);
               check(out_data == 16'sd0, "R3", "out_data during fill", longint'(out_data), 0);
            end
            k++;
         end else begin
            check(out_valid == 1'b0, "R4", "out_valid on idle", longint'(out_valid), 0);
            check(longint'(out_data) == last, "R4", "out_data on idle", longint'(out_data), last);
         end
         last = longint'(out_data);
      end
      in_valid = 1'b0;
   endtask

   task automatic test_impulse();
      xs[0] = 16000;
      for (int j = 1; j < 24; j++) xs[j] = 0;
      load_coefs(65536, 32768);            // a = 0.5, b = 0.25
      build_model(65536, 32768, 24);
      check(ym[1] == 4000, "R1", "model first tap", ym[1], 4000);
      run_stream(24, 0, 1'b1);
   endtask

   task automatic test_gaps();
      for (int j = 0; j < 200; j++) xs[j] = int'($urandom_range(16000)) - 8000;
      load_coefs(-57344, 65536);           // a = -0.4375, b = 0.5
      build_model(-57344, 65536, 200);
      run_stream(200, 30, 1'b1);
   endtask

   task automatic test_direct();
      for (int j = 0; j < 150; j++) xs[j] = int'($urandom_range(16000)) - 8000;
      load_coefs(65536, 49152);            // a = 0.5, b = 0.375
      build_model(65536, 49152, 150);
      run_stream(150, 0, 1'b1);
   endtask

   task automatic test_saturation();
      for (int j = 0; j < 40; j++) xs[j] = 30000;
      load_coefs(122880, 65536);           // a = 0.9375, b = 0.5
      build_model(122880, 65536, 40);
      run_stream(40, 10, 1'b0);
      check(out_data == 16'sh7fff, "R6", "positive rail", longint'(out_data), 32767);
      for (int j = 0; j < 40; j++) xs[j] = -30000;
      load_coefs(122880, 65536);
      build_model(122880, 65536, 40);
      run_stream(40, 0, 1'b0);
      check(out_data == -16'sd32768, "R6", "negative rail", longint'(out_data), -32768);
   endtask

   task automatic test_neg_one();
      xs[0] = 1000;
      for (int j = 1; j < 30; j++) xs[j] = 0;
      load_coefs(-131072, 65536);          // a = -1.0, b = 0.5
      build_model(-131072, 65536, 30);
      run_stream(30, 20, 1'b0);
      check(out_data == 16'sd500 || out_data == -16'sd500, "R9", "sustained oscillation",
            longint'(out_data), 500);
   endtask

   task automatic test_load_mid();
      for (int j = 0; j < 40; j++) xs[j] = int'($urandom_range(20000)) - 10000;
      load_coefs(65536, 65536);
      build_model(65536, 65536, 40);
      run_stream(40, 0, 1'b0);
      load_coefs(32768, 98304);            // new set mid-stream: a = 0.25, b = 0.75
      for (int j = 0; j < 40; j++) xs[j] = int'($urandom_range(20000)) - 10000;
      build_model(32768, 98304, 40);
      run_stream(40, 15, 1'b0);
   endtask

   task automatic test_reset_mid();
      for (int j = 0; j < 30; j++) xs[j] = int'($urandom_range(20000)) - 10000;
      load_coefs(81920, 65536);
      build_model(81920, 65536, 30);
      run_stream(30, 0, 1'b0);
      do_reset();
      build_model(0, 0, 30);               // coefficients are zero after reset
      run_stream(30, 0, 1'b0);
      check(out_data == 16'sd0, "R7", "output with cleared coefficients", longint'(out_data), 0);
   endtask

   initial begin
      void'($urandom(7));
      do_reset();
      test_impulse();
      test_gaps();
      test_direct();
      test_saturation();
      test_neg_one();
      test_load_mid();
      test_reset_mid();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule